// File: doc/BRIEF.md
# Barrel Shifter and Rotator with Carry Flag

This unit is a purely combinational shift stage for a small processor datapath. It takes a data word and an unsigned shift count. It either shifts the word left and fills the vacated low bits with zeros, or rotates it right. It also works out the next value of the carry flag. Both the result and the carry settle in the same cycle as the inputs, so the unit sits directly between operand fetch and the flag and writeback logic.

The carry rules are the core of the block, not a side effect. The output carry is:
- for a left shift, the last bit pushed out of the word;
- for a rotate, the bit that lands in the top position;
- the incoming carry, unchanged, when the count is zero.

Counts equal to or larger than the word width are exact:
- a left shift by more than the width clears both the word and the carry;
- a rotate reduces the count modulo the width;
- a nonzero multiple of the width behaves as a full-width rotate.

A flag-update enable lets the caller keep the old carry for every operation. The word width and the count width are parameters (defaults 32 and 8). There is no handshake: the unit has no state, and its outputs simply follow its inputs.

Top module: `shc_shift_unit`

## Requirements
- R1: With `op_i` = 0 (left shift) and a count n in 1..W-1, `result_o` equals `operand_i` shifted left by n, with result bits [n-1:0] all zero.
- R2: With `op_i` = 0, `flag_en_i` = 1 and n in 1..W, `carry_o` equals operand bit [W-n], the last bit shifted out (bit 0 when n = W).
- R3: With `op_i` = 0 and n of W or more, `result_o` is all zeros; if in addition n > W and `flag_en_i` = 1, `carry_o` is 0.
- R4: A count of zero gives `result_o` = `operand_i` and `carry_o` = `carry_i` for both operations, regardless of `flag_en_i`.
- R5: With `op_i` = 1 (rotate right), let r = n mod W with r nonzero; `result_o` equals `operand_i` rotated right by r places, operand bits [r-1:0] landing in result bits [W-1:W-r].
- R6: With `op_i` = 1, `flag_en_i` = 1 and r nonzero, `carry_o` equals operand bit [r-1].
- R7: With `op_i` = 1 and n a nonzero multiple of W, `result_o` equals `operand_i`; with `flag_en_i` = 1, `carry_o` equals operand bit [W-1].
- R8: With `flag_en_i` = 0, `carry_o` equals `carry_i` for every operation and count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | W | Data word to shift or rotate |
| amount_i | input | AW | Unsigned shift or rotate count |
| op_i | input | 1 | 0 selects left shift, 1 selects rotate right |
| carry_i | input | 1 | Current carry flag |
| flag_en_i | input | 1 | 1 lets the operation update the carry |
| result_o | output | W | Shifted or rotated word |
| carry_o | output | 1 | Next carry flag |

## Verification
The bench builds the unit with its defaults, W = 32 and AW = 8. The 8-bit count therefore reaches every value from 0 to 255. That range covers:
- the zero count;
- every in-range count;
- the exact-width count of 32;
- counts just above the width;
- every nonzero multiple of 32 (32, 64, 96, ... 224).

Every count is swept for both operations, both enable settings and both carry inputs. The operands are edge patterns (single bits at each end, alternating bits, all ones) plus pseudo-random words. Each result is compared with a reference computed arithmetically from a double-width word.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic {
    SHC_OP_LSL = 1'b0,
    SHC_OP_ROR = 1'b1
  } shc_op_e;
endpackage

// File: rtl/shc_amt_dec.sv
module shc_amt_dec #(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int LW = $clog2(W)
) (
  input  logic [AW-1:0] amount_i,
  output logic [LW-1:0] amt_low_o,
  output logic          amt_zero_o,
  output logic          amt_eq_w_o,
  output logic          amt_gt_w_o
);
  localparam logic [AW:0] W_EXT = (AW+1)'(W);

  always_comb begin
    amt_low_o  = amount_i[LW-1:0];
    amt_zero_o = (amount_i == '0);
    amt_eq_w_o = ({1'b0, amount_i} == W_EXT);
    amt_gt_w_o = ({1'b0, amount_i} > W_EXT);
  end
endmodule

// File: rtl/shc_lsl_core.sv
module shc_lsl_core #(
  parameter int W = 32,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  operand_i,
  input  logic [LW-1:0] amt_i,
  output logic [W-1:0]  word_o,
  output logic          spill_o
);
  logic [W:0] stage [0:LW];

  assign stage[0] = {1'b0, operand_i};

  for (genvar s = 0; s < LW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? (stage[s] << STEP) : stage[s];
  end

  assign word_o  = stage[LW][W-1:0];
  assign spill_o = stage[LW][W];
endmodule

// File: rtl/shc_ror_core.sv
module shc_ror_core #(
  parameter int W = 32,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  operand_i,
  input  logic [LW-1:0] amt_i,
  output logic [W-1:0]  word_o
);
  logic [W-1:0] stage [0:LW];

  assign stage[0] = operand_i;

  for (genvar s = 0; s < LW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][STEP-1:0], stage[s][W-1:STEP]}
                                 : stage[s];
  end

  assign word_o = stage[LW];
endmodule

// File: rtl/shc_flag_sel.sv
module shc_flag_sel
  import shc_pkg::*;
#(
  parameter int W = 32
) (
  input  shc_op_e      op_i,
  input  logic         flag_en_i,
  input  logic         carry_i,
  input  logic         amt_zero_i,
  input  logic         amt_eq_w_i,
  input  logic         amt_gt_w_i,
  input  logic         operand_lsb_i,
  input  logic [W-1:0] lsl_word_i,
  input  logic         lsl_spill_i,
  input  logic [W-1:0] ror_word_i,
  output logic [W-1:0] result_o,
  output logic         carry_o
);
  logic new_carry;

  always_comb begin
    if (op_i == SHC_OP_LSL) begin
      result_o = (amt_eq_w_i || amt_gt_w_i) ? '0 : lsl_word_i;
      if (amt_zero_i)      new_carry = carry_i;
      else if (amt_eq_w_i) new_carry = operand_lsb_i;
      else if (amt_gt_w_i) new_carry = 1'b0;
      else                 new_carry = lsl_spill_i;
    end else begin
      result_o  = ror_word_i;
      new_carry = amt_zero_i ? carry_i : ror_word_i[W-1];
    end
    carry_o = flag_en_i ? new_carry : carry_i;
  end

  always_comb begin
    if (!flag_en_i) AST_HOLD_CARRY: assert (carry_o == carry_i); // R8
  end
endmodule

// File: rtl/shc_shift_unit.sv
module shc_shift_unit
  import shc_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  operand_i,
  input  logic [AW-1:0] amount_i,
  input  logic          op_i,
  input  logic          carry_i,
  input  logic          flag_en_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  logic [LW-1:0] amt_low;
  logic          amt_zero;
  logic          amt_eq_w;
  logic          amt_gt_w;
  logic [W-1:0]  lsl_word;
  logic          lsl_spill;
  logic [W-1:0]  ror_word;
  shc_op_e       op_sel;

  assign op_sel = shc_op_e'(op_i);

  shc_amt_dec #(.W(W), .AW(AW)) u_dec (
    .amount_i   (amount_i),
    .amt_low_o  (amt_low),
    .amt_zero_o (amt_zero),
    .amt_eq_w_o (amt_eq_w),
    .amt_gt_w_o (amt_gt_w)
  );

  shc_lsl_core #(.W(W)) u_lsl (
    .operand_i (operand_i),
    .amt_i     (amt_low),
    .word_o    (lsl_word),
    .spill_o   (lsl_spill)
  );

  shc_ror_core #(.W(W)) u_ror (
    .operand_i (operand_i),
    .amt_i     (amt_low),
    .word_o    (ror_word)
  );

  shc_flag_sel #(.W(W)) u_sel (
    .op_i          (op_sel),
    .flag_en_i     (flag_en_i),
    .carry_i       (carry_i),
    .amt_zero_i    (amt_zero),
    .amt_eq_w_i    (amt_eq_w),
    .amt_gt_w_i    (amt_gt_w),
    .operand_lsb_i (operand_i[0]),
    .lsl_word_i    (lsl_word),
    .lsl_spill_i   (lsl_spill),
    .ror_word_i    (ror_word),
    .result_o      (result_o),
    .carry_o       (carry_o)
  );

  always_comb begin
    if (amount_i == '0) begin
      AST_ZERO_PASS: assert (result_o == operand_i && carry_o == carry_i); // R4
    end
    if (!op_i && ({1'b0, amount_i} >= (AW+1)'(W))) begin
      AST_LSL_FLUSH: assert (result_o == '0); // R3
    end
    if (!op_i && amount_i != '0 && ({1'b0, amount_i} < (AW+1)'(W))) begin
      AST_LSL_LOW_CLEAR: assert (result_o[0] == 1'b0); // R1
    end
    if (op_i) begin
      AST_ROR_KEEPS_ONES: assert ($countones(result_o) == $countones(operand_i)); // R5
    end
    if (op_i && amount_i != '0 && amount_i[LW-1:0] == '0) begin
      AST_ROR_FULL_TURN: assert (result_o == operand_i); // R7
    end
  end
endmodule

// File: tb/shc_shift_unit_test.sv
module shc_shift_unit_test;
  localparam int W  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  operand;
  logic [AW-1:0] amount;
  logic          op;
  logic          cin;
  logic          fen;
  logic [W-1:0]  result;
  logic          cout;

  int  total = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  shc_shift_unit #(.W(W), .AW(AW)) uut (
    .operand_i (operand),
    .amount_i  (amount),
    .op_i      (op),
    .carry_i   (cin),
    .flag_en_i (fen),
    .result_o  (result),
    .carry_o   (cout)
  );

  task automatic check_word(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d amt=%0d opnd=%h: result %h expected %h", tag, op, amount, operand, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d amt=%0d opnd=%h fen=%0d cin=%0d: carry %0d expected %0d",
               tag, op, amount, operand, fen, cin, act, exp);
    end
  endtask

  task automatic run_vec(input logic [W-1:0] v, input int n, input bit o, input bit f, input bit c);
    logic [2*W-1:0] ext;
    logic [W-1:0]   exp_r;
    logic           exp_c;
    int             r;
    string          rtag;
    string          ctag;
    @(posedge clk);
    operand = v; amount = AW'(n); op = o; fen = f; cin = c;
    if (!o) begin
      ext   = {{W{1'b0}}, v} << n;
      exp_r = ext[W-1:0];
      exp_c = (n == 0) ? c : ext[W];
      rtag  = (n == 0) ? "R4" : (n < W) ? "R1" : "R3";
      ctag  = (n == 0) ? "R4" : (n <= W) ? "R2" : "R3";
    end else begin
      r     = n % W;
      ext   = {v, v} >> r;
      exp_r = ext[W-1:0];
      if (n == 0)      exp_c = c;
      else if (r == 0) exp_c = v[W-1];
      else             exp_c = v[r-1];
      rtag  = (n == 0) ? "R4" : (r == 0) ? "R7" : "R5";
      ctag  = (n == 0) ? "R4" : (r == 0) ? "R7" : "R6";
    end
    if (!f) begin
      exp_c = c;
      ctag  = "R8";
    end
    @(negedge clk);
    check_word(rtag, result, exp_r);
    check_bit(ctag, cout, exp_c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [0:9];
    logic [W-1:0] lfsr;
    operand = '0; amount = '0; op = 1'b0; cin = 1'b0; fen = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_word("R4 reset", result, '0);
    check_bit("R4 reset", cout, 1'b0);

    pats[0] = 32'h0000_0001;
    pats[1] = 32'h8000_0000;
    pats[2] = 32'hAAAA_AAAA;
    pats[3] = 32'h5555_5555;
    pats[4] = 32'hFFFF_FFFF;
    lfsr = 32'h1D87_2B41;
    for (int i = 5; i < 10; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      pats[i] = lfsr;
    end

    for (int p = 0; p < 10; p++)
      for (int o = 0; o < 2; o++)
        for (int f = 0; f < 2; f++)
          for (int c = 0; c < 2; c++)
            for (int n = 0; n < (1 << AW); n++)
              run_vec(pats[p], n, o[0], f[0], c[0]);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule